// File: doc/BRIEF.md
# Slave port arbiter with burst-aware re-arbitration

This block decides which of several bus masters owns one slave port of a multi-master interconnect. Each master presents a request line and the attributes of its current transfer: the transfer kind, the burst kind and whether the slave accepted the beat. The arbiter registers a one-hot grant and changes it only at cycles where breaking the current access is safe. These are an idle slave, a completed single access, the last beat of a burst, or an access that has held the slave for too many cycles.

Each slave port gets its own instance, so different slaves can run different policies side by side. Per-slave inputs choose round-robin or fixed-priority selection, name a default master that receives the port when nobody requests it, and set a slot cycle limit. Per-master inputs choose where an undefined-length incrementing burst is given a predicted end, so that other masters can get in. The data and address multiplexers that consume the grant live outside this block.

Top module: `slave_arbiter`

## Requirements
- R1: While `rst` is high the grant is all zeros. The grant is registered and never has more than one bit set. From the first clock edge after reset it has exactly one bit set.
- R2: With `cfg_fixed_prio` = 1, an arbitration point grants the requesting master with the lowest index.
- R3: If no `req` bit is set at an arbitration point, the grant goes to master `cfg_def_master`.
- R4: With `cfg_fixed_prio` = 0, an arbitration point grants the first requesting master after the most recently granted requester, searching upward and wrapping from the highest index to 0.
- R5: The grant does not change after a cycle that is not an arbitration point.
- R6: Defined-length bursts end on their last accepted beat, and that cycle is an arbitration point. Burst codes: 0 single, 1 undefined-length incrementing, 2 wrap-4, 3 incr-4, 4 wrap-8, 5 incr-8, 6 wrap-16, 7 incr-16. The lengths are 4, 8 and 16 beats.
- R7: Beat counting uses only beats the owner presents as NONSEQ or SEQ while `ready` is 1. Cycles with `ready` = 0 and BUSY cycles do not advance it. A NONSEQ restarts the count at beat 0.
- R8: A single access (transfer code NONSEQ = 2 with burst code 0) is an arbitration point on the cycle it is accepted (`ready` = 1), and only then.
- R9: For an undefined-length burst, the owner's 2-bit `cut_sel` field gives the predicted end. Code 0 means never. Codes 1, 2 and 3 put an arbitration point on every accepted beat whose index modulo 4, 8 or 16 equals that size minus one.
- R10: With `cfg_slot_limit` = L > 0, the L-th cycle after a grant decision is an arbitration point whatever the transfer. L = 0 disables this.
- R11: The slave is idle when no master owns it or the owner drives transfer code IDLE = 0. Every idle cycle is an arbitration point. Transfer codes: 0 IDLE, 1 BUSY, 2 NONSEQ, 3 SEQ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N_MASTERS | Request line per master |
| trans | input | 2*N_MASTERS | Transfer code per master, master i at bits [2i+1:2i] |
| burst | input | 3*N_MASTERS | Burst code per master, master i at bits [3i+2:3i] |
| cut_sel | input | 2*N_MASTERS | Undefined-length burst cut choice per master |
| ready | input | 1 | Slave accepts the current beat |
| cfg_fixed_prio | input | 1 | 1 selects fixed priority, 0 selects round-robin |
| cfg_def_master | input | IDX_W | Master that receives the port when nobody requests |
| cfg_slot_limit | input | SLOT_W | Slot cycle limit, 0 disables |
| grant | output | N_MASTERS | Registered one-hot grant |

## Verification
The properties assume that `cfg_def_master` names an existing master. They also assume that configuration and requests are steady across the clock edge where a decision is made, because the checks compare the new grant with the sampled request vector. The bench changes inputs only at falling edges and keeps the default index in range. It starts every burst with NONSEQ, so the beat positions the properties and the expected grants rely on are well defined. Slot limits are changed only while the owner is idle.

// File: rtl/slvarb_pkg.sv
package slvarb_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'd0,
        TR_BUSY   = 2'd1,
        TR_NONSEQ = 2'd2,
        TR_SEQ    = 2'd3
    } trans_e;

    typedef enum logic [2:0] {
        BK_SINGLE = 3'd0,
        BK_INCR   = 3'd1,
        BK_WRAP4  = 3'd2,
        BK_INCR4  = 3'd3,
        BK_WRAP8  = 3'd4,
        BK_INCR8  = 3'd5,
        BK_WRAP16 = 3'd6,
        BK_INCR16 = 3'd7
    } burst_e;

    typedef enum logic [1:0] {
        CUT_NONE = 2'd0,
        CUT_4    = 2'd1,
        CUT_8    = 2'd2,
        CUT_16   = 2'd3
    } cut_e;

    localparam int BEAT_W = 4;

    // attributes of the master that currently owns the slave
    typedef struct packed {
        logic [1:0] trans;
        logic [2:0] burst;
        logic [1:0] cut;
    } attr_t;

    // predicted burst end: bounded flag plus beat-index mask
    typedef struct packed {
        logic              bounded;
        logic [BEAT_W-1:0] mask;
    } span_t;

    function automatic span_t burst_span(input logic [2:0] b, input logic [1:0] c);
        span_t s;
        s.bounded = 1'b1;
        s.mask    = '0;
        case (burst_e'(b))
            BK_SINGLE: s.bounded = 1'b0;
            BK_INCR: begin
                case (cut_e'(c))
                    CUT_4:   s.mask = 4'd3;
                    CUT_8:   s.mask = 4'd7;
                    CUT_16:  s.mask = 4'd15;
                    default: s.bounded = 1'b0;
                endcase
            end
            BK_WRAP4, BK_INCR4: s.mask = 4'd3;
            BK_WRAP8, BK_INCR8: s.mask = 4'd7;
            default:            s.mask = 4'd15;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/slvarb_owner_mux.sv
module slvarb_owner_mux #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [2*N-1:0]         trans,
    input  logic [3*N-1:0]         burst,
    input  logic [2*N-1:0]         cut_sel,
    input  logic [IDX_W-1:0]       owner_idx,
    output slvarb_pkg::attr_t      owner
);
    always_comb begin
        owner = '0;
        for (int i = 0; i < N; i++) begin
            if (owner_idx == IDX_W'(i)) begin
                owner.trans = trans[2*i +: 2];
                owner.burst = burst[3*i +: 3];
                owner.cut   = cut_sel[2*i +: 2];
            end
        end
    end
endmodule

// File: rtl/slvarb_point.sv
module slvarb_point
    import slvarb_pkg::*;
#(
    parameter int SLOT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              owner_vld,
    input  attr_t             owner,
    input  logic              ready,
    input  logic [SLOT_W-1:0] slot_limit,
    output logic              arb_pt
);
    logic [BEAT_W-1:0] beat_q;
    logic [BEAT_W-1:0] cur_idx;
    logic [SLOT_W-1:0] slot_q;
    logic              active, idle, single_done, burst_end, slot_hit;
    span_t             span;

    always_comb begin
        active      = (owner.trans == TR_NONSEQ) || (owner.trans == TR_SEQ);
        idle        = !owner_vld || (owner.trans == TR_IDLE);
        cur_idx     = (owner.trans == TR_NONSEQ) ? '0 : beat_q;
        span        = burst_span(owner.burst, owner.cut);
        single_done = ready && (owner.trans == TR_NONSEQ) && (owner.burst == BK_SINGLE);
        burst_end   = ready && active && span.bounded && ((cur_idx & span.mask) == span.mask);
        slot_hit    = (slot_limit != '0) && (slot_q >= slot_limit - 1'b1);
        arb_pt      = idle || single_done || burst_end || slot_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
            slot_q <= '0;
        end else begin
            if (active && ready)
                beat_q <= cur_idx + 1'b1;
            if (arb_pt)
                slot_q <= '0;
            else if (slot_q != '1)
                slot_q <= slot_q + 1'b1;
        end
    end
endmodule

// File: rtl/slvarb_pick.sv
module slvarb_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     req,
    input  logic             fixed_prio,
    input  logic [IDX_W-1:0] last_idx,
    input  logic [IDX_W-1:0] def_idx,
    output logic [IDX_W-1:0] win_idx
);
    logic [IDX_W-1:0] cand;

    always_comb begin
        win_idx = def_idx;
        cand    = '0;
        if (fixed_prio) begin
            for (int i = N - 1; i >= 0; i--)
                if (req[i]) win_idx = IDX_W'(i);
        end else begin
            // descending distance: the nearest requester after last wins
            for (int k = N; k >= 1; k--) begin
                cand = IDX_W'((int'(last_idx) + k) % N);
                if (req[cand]) win_idx = cand;
            end
        end
    end
endmodule

// File: rtl/slave_arbiter.sv
module slave_arbiter
    import slvarb_pkg::*;
#(
    parameter int  N_MASTERS = 4,
    parameter int  SLOT_W    = 8,
    localparam int IDX_W     = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_MASTERS-1:0]   req,
    input  logic [2*N_MASTERS-1:0] trans,
    input  logic [3*N_MASTERS-1:0] burst,
    input  logic [2*N_MASTERS-1:0] cut_sel,
    input  logic                   ready,
    input  logic                   cfg_fixed_prio,
    input  logic [IDX_W-1:0]       cfg_def_master,
    input  logic [SLOT_W-1:0]      cfg_slot_limit,
    output logic [N_MASTERS-1:0]   grant
);
    logic [N_MASTERS-1:0] grant_q;
    logic [IDX_W-1:0]     owner_idx_q, last_q, win_idx;
    logic                 owner_vld_q;
    logic                 arb_pt;
    attr_t                owner;

    slvarb_owner_mux #(.N(N_MASTERS), .IDX_W(IDX_W)) u_mux (
        .trans     (trans),
        .burst     (burst),
        .cut_sel   (cut_sel),
        .owner_idx (owner_idx_q),
        .owner     (owner)
    );

    slvarb_point #(.SLOT_W(SLOT_W)) u_point (
        .clk        (clk),
        .rst        (rst),
        .owner_vld  (owner_vld_q),
        .owner      (owner),
        .ready      (ready),
        .slot_limit (cfg_slot_limit),
        .arb_pt     (arb_pt)
    );

    slvarb_pick #(.N(N_MASTERS), .IDX_W(IDX_W)) u_pick (
        .req        (req),
        .fixed_prio (cfg_fixed_prio),
        .last_idx   (last_q),
        .def_idx    (cfg_def_master),
        .win_idx    (win_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q     <= '0;
            owner_idx_q <= '0;
            owner_vld_q <= 1'b0;
            last_q      <= '0;
        end else if (arb_pt) begin
            grant_q     <= N_MASTERS'(1) << win_idx;
            owner_idx_q <= win_idx;
            owner_vld_q <= 1'b1;
            if (|req)
                last_q <= win_idx;
        end
    end

    assign grant = grant_q;
endmodule

// File: rtl/slvarb_checker.sv
module slvarb_checker #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic [N-1:0]     req,
    input logic             cfg_fixed_prio,
    input logic [IDX_W-1:0] cfg_def_master,
    input logic [N-1:0]     grant,
    input logic             arb_pt
);
    AST_GRANT_ONEHOT0: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)); // R1

    AST_HOLD_OFF_POINT: assert property (@(posedge clk) disable iff (rst)
        !arb_pt |=> $stable(grant)); // R5

    AST_FIXED_LOWEST: assert property (@(posedge clk) disable iff (rst)
        (arb_pt && cfg_fixed_prio && (|req))
        |=> grant == ($past(req) & (~$past(req) + N'(1)))); // R2

    AST_IDLE_DEFAULT: assert property (@(posedge clk) disable iff (rst)
        (arb_pt && !(|req)) |=> grant == (N'(1) << $past(cfg_def_master))); // R3

    AST_GRANT_REQUESTER: assert property (@(posedge clk) disable iff (rst)
        (arb_pt && (|req)) |=> (|(grant & $past(req)))); // R4
endmodule

bind slave_arbiter slvarb_checker #(.N(N_MASTERS), .IDX_W(IDX_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .req            (req),
    .cfg_fixed_prio (cfg_fixed_prio),
    .cfg_def_master (cfg_def_master),
    .grant          (grant),
    .arb_pt         (arb_pt)
);

// File: tb/slave_arbiter_tb.sv
module slave_arbiter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] req = '0;
    logic [1:0]   tr [N];
    logic [2:0]   bk [N];
    logic [1:0]   ct [N];
    logic [2*N-1:0] trans_v, cut_v;
    logic [3*N-1:0] burst_v;
    logic         ready = 1'b1;
    logic         fixed = 1'b1;
    logic [1:0]   def_m = 2'd2;
    logic [7:0]   limit = 8'd0;
    logic [N-1:0] grant;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            trans_v[2*i +: 2] = tr[i];
            burst_v[3*i +: 3] = bk[i];
            cut_v[2*i +: 2]   = ct[i];
        end
    end

    slave_arbiter u_dut (
        .clk(clk), .rst(rst), .req(req), .trans(trans_v), .burst(burst_v),
        .cut_sel(cut_v), .ready(ready), .cfg_fixed_prio(fixed),
        .cfg_def_master(def_m), .cfg_slot_limit(limit), .grant(grant)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s grant=%b expected=%b", tag, got, exp);
        end
    endtask

    task automatic idle_all();
        for (int i = 0; i < N; i++) begin
            tr[i] = 2'd0;
            bk[i] = 3'd0;
            ct[i] = 2'd0;
        end
    endtask

    // give the port to master m through a fixed-priority idle decision
    task automatic take(input int m);
        fixed = 1'b1;
        req   = N'(1) << m;
        idle_all();
        ready = 1'b1;
        step();
        chk("R2 take", grant, N'(1) << m);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        idle_all();
        repeat (3) step();
        chk("R1 reset", grant, 4'b0000);
        rst = 1'b0;

        // R3 / R11: idle slave, nobody requesting
        step();
        chk("R3 default after reset", grant, 4'b0100);
        def_m = 2'd1;
        step();
        chk("R3 default change R11", grant, 4'b0010);
        def_m = 2'd2;

        // R2 fixed priority
        req = 4'b1010; step(); chk("R2 lowest", grant, 4'b0010);
        req = 4'b1100; step(); chk("R2 lowest", grant, 4'b0100);

        // R4 round robin, last granted = 2, idle owner every cycle (R11)
        fixed = 1'b0;
        req = 4'b1011;
        step(); chk("R4 rr", grant, 4'b1000);
        step(); chk("R4 rr wrap", grant, 4'b0001);
        step(); chk("R4 rr R11", grant, 4'b0010);
        step(); chk("R4 rr", grant, 4'b1000);

        // R5 R6 R7 incr-4 burst with a wait state and a BUSY cycle
        take(0);
        fixed = 1'b0; req = 4'b0111; bk[0] = 3'd3;
        tr[0] = 2'd2; step(); chk("R5 beat0", grant, 4'b0001);
        tr[0] = 2'd3; step(); chk("R5 beat1", grant, 4'b0001);
        ready = 1'b0; step(); chk("R7 wait", grant, 4'b0001);
        ready = 1'b1; tr[0] = 2'd1; step(); chk("R7 busy", grant, 4'b0001);
        tr[0] = 2'd3; step(); chk("R5 beat2", grant, 4'b0001);
        step(); chk("R6 last beat", grant, 4'b0010);

        // R6 wrap-8 burst
        take(1);
        fixed = 1'b0; req = 4'b0011; bk[1] = 3'd4;
        for (int i = 0; i < 8; i++) begin
            tr[1] = (i == 0) ? 2'd2 : 2'd3;
            step();
            chk("R6 wrap8", grant, (i == 7) ? 4'b0001 : 4'b0010);
        end

        // R8 single access, only when accepted
        take(2);
        fixed = 1'b0; req = 4'b0110; tr[2] = 2'd2; bk[2] = 3'd0;
        ready = 1'b0; step(); chk("R8 single waited", grant, 4'b0100);
        ready = 1'b1; step(); chk("R8 single done", grant, 4'b0010);

        // R9 undefined-length cuts 4, 8, 16
        for (int c = 1; c <= 3; c++) begin
            int len;
            len = 4 << (c - 1);
            take(0);
            fixed = 1'b0; req = 4'b0011; ct[0] = 2'(c); bk[0] = 3'd1;
            for (int i = 0; i < len; i++) begin
                tr[0] = (i == 0) ? 2'd2 : 2'd3;
                step();
                chk("R9 cut", grant, (i == len - 1) ? 4'b0010 : 4'b0001);
            end
        end

        // R9 never cut: 20 beats hold
        take(0);
        fixed = 1'b0; req = 4'b0011; ct[0] = 2'd0; bk[0] = 3'd1;
        for (int i = 0; i < 20; i++) begin
            tr[0] = (i == 0) ? 2'd2 : 2'd3;
            step();
            chk("R9 infinite R10 off", grant, 4'b0001);
        end

        // R10 slot limit 5 breaks the endless burst
        take(0);
        limit = 8'd5;
        fixed = 1'b0; req = 4'b0011; ct[0] = 2'd0; bk[0] = 3'd1;
        for (int i = 1; i <= 5; i++) begin
            tr[0] = (i == 1) ? 2'd2 : 2'd3;
            step();
            chk("R10 slot", grant, (i == 5) ? 4'b0010 : 4'b0001);
        end
        limit = 8'd0;

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule